// File: doc/BRIEF.md
# Banked Interrupt Controller with Cascade

This block gathers up to 32 interrupt sources per bank and presents them to a host through four 32-bit registers per bank. Sources marked edge-type are caught in a sticky event latch on a rising edge of the synchronised input. Sources marked level-type bypass the latch and are taken live from the input. Both kinds are gated by a per-source enable. The OR of the primary bank's gated sources drives a single request line.

A second bank can be instantiated as a cascade. Its own request is fed into one fixed source position of the primary bank, and that position is treated as level-type there. A priority encoder reports the highest-numbered pending source. It looks at the secondary bank first and adds 32 to any index it takes from there. Software services a source by writing a one to its acknowledge bit.

Top module: `intc_top`

## Requirements
- R1: The byte address bits [3:2] select the register: 0x0 event (read only), 0x4 enable (read/write), 0x8 acknowledge (write only, reads 0), 0xC level (read only). Address bit 4 selects the bank (0 = primary, 1 = secondary). A read returns its data on `rdata_o` with `rvalid_o` high one clock after `sel_i` is sampled with `we_i` low.
- R2: After reset, both banks read enable 0 and event 0, and `irq_o` and `pend_valid_o` are low.
- R3: An edge-type event bit sets only on a rising edge of its synchronised input that occurs while its enable bit is 1. An edge that arrives while the source is disabled is not remembered.
- R4: Setting the enable bit of an edge-type source whose input is already high sets neither its event bit nor `irq_o`.
- R5: Writing 1 to an acknowledge bit clears that event bit, and writing 0 leaves it unchanged. If a new rising edge and an acknowledge reach the same bit in the same clock, the bit stays set.
- R6: The level register reads the synchronised state of every input, whatever the enable register holds.
- R7: Sources in the level mask (default bits 20 to 28) are pending while their input is high and enabled, and stop being pending when the input falls, with no acknowledge. Their event bits stay 0.
- R8: `irq_o` is the OR over the primary bank of (event OR (live input AND level mask)) AND enable.
- R9: `pend_idx_o` is the highest-numbered pending source. When nothing is pending, `pend_valid_o` is 0 and `pend_idx_o` is 0.
- R10: The secondary bank's request drives primary source 30 as a level-type input, visible in the primary level register. Secondary sources are reported first, at index 32 plus their bit number, even when `irq_o` is masked or a primary source is also pending.
- R11: Writes to the event or level register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Raw sources, bank 1 in bits 63:32 |
| sel_i | input | 1 | Register access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address: bank in bit 4, register in bits 3:2 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request from the primary bank |
| pend_valid_o | output | 1 | Some source pending in either bank |
| pend_idx_o | output | 6 | Highest pending source index |

## Verification
The assertions assume that `sel_i` is held low while reset is asserted, so the read-valid relation starts cleanly. They also assume that the sources are steady long enough to pass the two-flop synchroniser. The stimulus changes sources and bus signals only on falling edges, holds each source level for several clocks, and keeps the bus idle during reset. The one case with a same-cycle collision, an acknowledge landing on the clock that samples a new edge, is placed by counting the synchroniser stages from the falling edge that raises the input.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK    = 2'd2,
    REG_LEVEL  = 2'd3
  } intc_reg_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int           W        = 32,
  parameter logic [W-1:0] LVL_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         wr_i,
  input  intc_reg_e    wreg_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] evt_q, en_q, prev_q;
  logic [W-1:0] rise, ack, evt_d, en_d;

  // edge capture only for enabled edge-type bits
  assign rise = src_i & ~prev_q & en_q & ~LVL_MASK;
  assign ack  = (wr_i && wreg_i == REG_ACK) ? wdata_i : '0;
  assign en_d = (wr_i && wreg_i == REG_ENABLE) ? wdata_i : en_q;
  // new edge beats acknowledge
  assign evt_d = (evt_q & ~ack) | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= '0;
      en_q   <= '0;
      prev_q <= '0;
    end else begin
      evt_q  <= evt_d;
      en_q   <= en_d;
      prev_q <= src_i;
    end
  end

  assign evt_o  = evt_q;
  assign en_o   = en_q;
  assign pend_o = (evt_q | (src_i & LVL_MASK)) & en_q;
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |vec_i;
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int              NUM_BANKS    = 2,
  parameter int              SRC_W        = 32,
  parameter int              ADDR_W       = 5,
  parameter int              CASC_SRC     = 30,
  parameter logic [SRC_W-1:0] LVL_MASK_PRI = 32'h1ff0_0000,
  parameter logic [SRC_W-1:0] LVL_MASK_SEC = 32'h1ff0_0000
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [NUM_BANKS*SRC_W-1:0]            src_i,
  input  logic                                  sel_i,
  input  logic                                  we_i,
  input  logic [ADDR_W-1:0]                     addr_i,
  input  logic [SRC_W-1:0]                      wdata_i,
  output logic [SRC_W-1:0]                      rdata_o,
  output logic                                  rvalid_o,
  output logic                                  irq_o,
  output logic                                  pend_valid_o,
  output logic [$clog2(NUM_BANKS*SRC_W)-1:0]    pend_idx_o
);
  localparam int TOT    = NUM_BANKS * SRC_W;
  localparam int IDX_W  = $clog2(TOT);
  localparam int SIDX_W = $clog2(SRC_W);
  localparam int BSEL_W = ADDR_W - 4;
  localparam logic [SRC_W-1:0] CASC_BIT =
      (NUM_BANKS > 1) ? (SRC_W'(1) << CASC_SRC) : '0;
  localparam logic [SRC_W-1:0] LVL_P_EFF = LVL_MASK_PRI | CASC_BIT;

  logic [TOT-1:0]   src_sync;
  logic             casc_irq;
  logic [BSEL_W-1:0] bsel;
  intc_reg_e        rsel;

  logic [SRC_W-1:0]  bank_src  [NUM_BANKS];
  logic [SRC_W-1:0]  bank_evt  [NUM_BANKS];
  logic [SRC_W-1:0]  bank_en   [NUM_BANKS];
  logic [SRC_W-1:0]  bank_pend [NUM_BANKS];
  logic              bank_vld  [NUM_BANKS];
  logic [SIDX_W-1:0] bank_idx  [NUM_BANKS];

  logic [SRC_W-1:0] pri_evt, pri_en;
  logic [SRC_W-1:0] rdata_q;
  logic             rvalid_q;

  assign bsel = addr_i[ADDR_W-1:4];
  assign rsel = intc_reg_e'(addr_i[3:2]);

  intc_sync #(.W(TOT)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_i),
    .q_o    (src_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [SRC_W-1:0] src_b, evt_b, en_b, pend_b;
    logic             vld_b;
    logic [SIDX_W-1:0] idx_b;

    if (b == 0 && NUM_BANKS > 1) begin : g_casc_in
      always_comb begin
        src_b = src_sync[SRC_W-1:0];
        src_b[CASC_SRC] = casc_irq;
      end
    end else begin : g_plain_in
      assign src_b = src_sync[b*SRC_W +: SRC_W];
    end

    if (b == 1) begin : g_casc_out
      assign casc_irq = |pend_b;
    end

    intc_bank #(
      .W        (SRC_W),
      .LVL_MASK ((b == 0) ? LVL_P_EFF : LVL_MASK_SEC)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_b),
      .wr_i    (sel_i && we_i && (int'(bsel) == b)),
      .wreg_i  (rsel),
      .wdata_i (wdata_i),
      .evt_o   (evt_b),
      .en_o    (en_b),
      .pend_o  (pend_b)
    );

    intc_prio #(.W(SRC_W), .IDX_W(SIDX_W)) u_prio (
      .vec_i   (pend_b),
      .valid_o (vld_b),
      .idx_o   (idx_b)
    );

    assign bank_src[b]  = src_b;
    assign bank_evt[b]  = evt_b;
    assign bank_en[b]   = en_b;
    assign bank_pend[b] = pend_b;
    assign bank_vld[b]  = vld_b;
    assign bank_idx[b]  = idx_b;
  end

  if (NUM_BANKS < 2) begin : g_no_casc
    assign casc_irq = 1'b0;
  end

  // higher bank wins
  always_comb begin
    pend_valid_o = 1'b0;
    pend_idx_o   = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_vld[b]) begin
        pend_valid_o = 1'b1;
        pend_idx_o   = IDX_W'(b * SRC_W) + IDX_W'(bank_idx[b]);
      end
    end
  end

  assign irq_o   = |bank_pend[0];
  assign pri_evt = bank_evt[0];
  assign pri_en  = bank_en[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= sel_i && !we_i;
      if (sel_i && !we_i) begin
        rdata_q <= '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (int'(bsel) == b) begin
            case (rsel)
              REG_EVENT:  rdata_q <= bank_evt[b];
              REG_ENABLE: rdata_q <= bank_en[b];
              REG_LEVEL:  rdata_q <= bank_src[b];
              default:    rdata_q <= '0;
            endcase
          end
        end
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NUM_BANKS = 2,
  parameter int SRC_W     = 32
) (
  input logic                                 clk_i,
  input logic                                 rst_ni,
  input logic                                 sel_i,
  input logic                                 we_i,
  input logic                                 rvalid_i,
  input logic                                 irq_i,
  input logic                                 pend_valid_i,
  input logic [$clog2(NUM_BANKS*SRC_W)-1:0]   pend_idx_i,
  input logic [SRC_W-1:0]                     evt0_i,
  input logic [SRC_W-1:0]                     en0_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r2: assert (en0_i == '0 && evt0_i == '0 && !irq_i);
    end
  end

  p_read_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i == $past(sel_i && !we_i));

  p_edge_needs_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt0_i & ~$past(evt0_i) & ~$past(en0_i)) == '0);

  p_irq_is_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> pend_valid_i);

  p_idle_index_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_valid_i |-> pend_idx_i == '0);
endmodule

bind intc_top intc_chk #(.NUM_BANKS(NUM_BANKS), .SRC_W(SRC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_i        (sel_i),
  .we_i         (we_i),
  .rvalid_i     (rvalid_o),
  .irq_i        (irq_o),
  .pend_valid_i (pend_valid_o),
  .pend_idx_i   (pend_idx_o),
  .evt0_i       (pri_evt),
  .en0_i        (pri_en)
);

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;
  localparam int EVT = 0, ENA = 1, ACK = 2, LVL = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src_i = '0;
  logic        sel_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o, irq_o, pend_valid_o;
  logic [5:0]  pend_idx_o;

  int n_tests = 0;
  int n_fail = 0;
  logic [31:0] rd;

  always #5 clk_i = ~clk_i;

  intc_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .sel_i(sel_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .irq_o(irq_o), .pend_valid_o(pend_valid_o), .pend_idx_o(pend_idx_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic wr(input int bank, input int r, input logic [31:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b1; addr_i = {bank[0], r[1:0], 2'b00}; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rdreg(input int bank, input int r, output logic [31:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b0; addr_i = {bank[0], r[1:0], 2'b00};
    @(negedge clk_i);
    sel_i = 1'b0;
    if (!rvalid_o) begin
      n_fail++;
      $display("FAIL R1: rvalid actual 0 expected 1");
    end
    d = rdata_o;
  endtask

  task automatic clean();
    src_i = '0;
    settle();
    for (int b = 0; b < 2; b++) begin
      wr(b, ENA, 32'h0);
      wr(b, ACK, 32'hffff_ffff);
    end
    settle();
  endtask

  task automatic t_reset();
    for (int b = 0; b < 2; b++) begin
      rdreg(b, ENA, rd); chk("R2 enable after reset", rd, 32'h0);
      rdreg(b, EVT, rd); chk("R2 event after reset", rd, 32'h0);
    end
    chk("R2 irq after reset", {31'd0, irq_o}, 32'h0);
    chk("R9 valid idle", {31'd0, pend_valid_o}, 32'h0);
    chk("R9 idx idle", {26'd0, pend_idx_o}, 32'h0);
    rdreg(0, ACK, rd); chk("R1 ack reads zero", rd, 32'h0);
  endtask

  task automatic t_edge();
    clean();
    src_i[3] = 1'b1; settle(); src_i[3] = 1'b0; settle();
    wr(0, ENA, 32'h8); settle();
    rdreg(0, EVT, rd); chk("R3 edge while disabled forgotten", rd, 32'h0);
    src_i[3] = 1'b1; settle();
    rdreg(0, EVT, rd); chk("R3 edge latched", rd, 32'h8);
    rdreg(0, ENA, rd); chk("R1 enable readback", rd, 32'h8);
    chk("R8 irq from edge", {31'd0, irq_o}, 32'h1);
    chk("R9 idx edge", {26'd0, pend_idx_o}, 32'd3);
    src_i[3] = 1'b0; settle();
    chk("R3 event sticky after input falls", {31'd0, irq_o}, 32'h1);
  endtask

  task automatic t_ack();
    wr(0, ACK, 32'h0);
    rdreg(0, EVT, rd); chk("R5 ack zero no effect", rd, 32'h8);
    wr(0, ACK, 32'h8);
    rdreg(0, EVT, rd); chk("R5 ack clears", rd, 32'h0);
    chk("R5 irq drops after ack", {31'd0, irq_o}, 32'h0);
  endtask

  task automatic t_simul();
    clean();
    wr(0, ENA, 32'h8);
    src_i[3] = 1'b1; settle(); src_i[3] = 1'b0; settle();
    @(negedge clk_i); src_i[3] = 1'b1;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    sel_i = 1'b1; we_i = 1'b1; addr_i = {1'b0, 2'd2, 2'b00}; wdata_i = 32'h8;
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0;
    rdreg(0, EVT, rd); chk("R5 new edge beats ack", rd, 32'h8);
  endtask

  task automatic t_en_high();
    clean();
    src_i[5] = 1'b1; settle();
    wr(0, ENA, 32'h20); settle();
    rdreg(0, EVT, rd); chk("R4 no event when enabled high", rd, 32'h0);
    chk("R4 no irq when enabled high", {31'd0, irq_o}, 32'h0);
  endtask

  task automatic t_level();
    clean();
    src_i[22] = 1'b1; src_i[4] = 1'b1; settle();
    rdreg(0, LVL, rd); chk("R6 level live while disabled", rd, 32'h0040_0010);
    chk("R7 disabled level no irq", {31'd0, irq_o}, 32'h0);
    wr(0, ENA, 32'h0040_0000); settle();
    chk("R7 level irq", {31'd0, irq_o}, 32'h1);
    chk("R9 idx level", {26'd0, pend_idx_o}, 32'd22);
    rdreg(0, EVT, rd); chk("R7 level event stays 0", rd, 32'h0);
    src_i[22] = 1'b0; settle();
    chk("R7 level clears with input", {31'd0, irq_o}, 32'h0);
  endtask

  task automatic t_ro();
    clean();
    wr(0, ENA, 32'h8);
    src_i[3] = 1'b1; settle();
    wr(0, EVT, 32'h0);
    rdreg(0, EVT, rd); chk("R11 event write zero ignored", rd, 32'h8);
    wr(0, EVT, 32'hffff_ffff);
    rdreg(0, EVT, rd); chk("R11 event write ones ignored", rd, 32'h8);
    wr(0, LVL, 32'h0);
    rdreg(0, LVL, rd); chk("R11 level write ignored", rd, 32'h8);
  endtask

  task automatic t_prio();
    clean();
    wr(0, ENA, 32'h88);
    src_i[3] = 1'b1; src_i[7] = 1'b1; settle();
    chk("R9 highest wins", {26'd0, pend_idx_o}, 32'd7);
    wr(0, ACK, 32'h80);
    chk("R9 next after ack", {26'd0, pend_idx_o}, 32'd3);
  endtask

  task automatic t_casc();
    clean();
    wr(0, ENA, 32'h8);
    src_i[3] = 1'b1; settle();
    wr(1, ENA, 32'h10);
    src_i[36] = 1'b1; settle();
    chk("R10 secondary first", {26'd0, pend_idx_o}, 32'd36);
    rdreg(0, LVL, rd); chk("R10 cascade in primary level", rd & 32'h4000_0000, 32'h4000_0000);
    wr(0, ENA, 32'h4000_0008); settle();
    chk("R10 cascade raises irq", {31'd0, irq_o}, 32'h1);
    wr(1, ACK, 32'h10); settle();
    chk("R10 back to primary", {26'd0, pend_idx_o}, 32'd3);
    rdreg(0, LVL, rd); chk("R10 cascade line drops", rd & 32'h4000_0000, 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_edge();
    t_ack();
    t_simul();
    t_en_high();
    t_level();
    t_ro();
    t_prio();
    t_casc();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule